// File: doc/BRIEF.md
# Transmit Command Consistency Checker

This block sits beside a transmit path and audits the host's per-buffer command words while the packet data is being written. Each buffer of a packet is announced by a pair of command words: word A gives the buffer's byte size and marks whether it opens and/or closes the packet, and word B gives the packet length and must be repeated unchanged for every buffer of that packet. The checker tracks this A/B sequence and counts the bytes the host actually writes. When the last buffer of the packet closes, it compares the packet's byte total with the declared length.

It also watches two overflow conditions. The first is a host write into a full transmit data FIFO. The second is a status write into a full status FIFO, which a configuration input can exempt. Any detected problem raises a sticky error flag and a one-cycle pulse. The checker never stalls the data path and keeps tracking the next packet after an error. It has no role in moving payload.

Top module: `tx_cmd_checker`

## Requirements
- R1: After reset, `err_flag` and `err_pulse` are both 0.
- R2: Word B is compared across all 32 bits. A word B on a non-first buffer that differs in any bit from the word B of that packet's first buffer is an error.
- R3: Word B bits [10:0] hold the packet length. A buffer closes when its written byte count reaches or passes its size, including a write that overshoots the size. When a buffer marked last closes, a packet byte total that differs from the length is an error, and an equal total is not.
- R4: A `data_wr` while `dfifo_full` is 1 is an error, in any sequencing state.
- R5: A `sfifo_wr` while `sfifo_full` is 1 is an error when `sts_ovr_allow` is 0, and has no effect when `sts_ovr_allow` is 1.
- R6: `err_flag` stays set until `err_clr` is 1, which clears it in the next cycle. A new error in the same cycle as `err_clr` leaves the flag set.
- R7: Errors are reported one cycle after the input that causes them. In that cycle `err_pulse` is 1 for exactly one cycle, however many errors coincided, and it is 0 in every cycle that follows an error-free cycle.
- R8: The following sequencing faults are errors: a word A while word B is still awaited, a word B with no pending word A, and a word A that arrives before the current buffer's bytes are complete. A non-first word A with no packet open is also an error, and that word A is then treated as opening a new packet.
- R9: After any error, checking continues, so a following correct packet raises no error.
- R10: A buffer whose size is 0 closes on its word B. If it is marked last, the length check of R3 happens in that same cycle.
- R11: Word A holds the buffer size in bits [10:0], the last-buffer bit at bit 12 and the first-buffer bit at bit 13. Data writes arriving while no buffer is waiting for bytes are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_a_stb | input | 1 | `cmd_word` carries word A this cycle |
| cmd_b_stb | input | 1 | `cmd_word` carries word B this cycle |
| cmd_word | input | 32 | Command word |
| data_wr | input | 1 | Host writes data into the transmit data FIFO |
| data_bytes | input | 3 | Valid bytes in this data write (0..4) |
| dfifo_full | input | 1 | Transmit data FIFO is full |
| sfifo_wr | input | 1 | A status word is written to the status FIFO |
| sfifo_full | input | 1 | Status FIFO is full |
| sts_ovr_allow | input | 1 | Status FIFO overrun is not treated as an error |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky error flag |
| err_pulse | output | 1 | One-cycle pulse per cycle with a detected error |

## Verification
A wrong internal state shows up at the ports as an error pulse in the wrong place. A stale reference word B, or a packet counter that is not reset on a first buffer, gives a spurious or missing pulse exactly one cycle after the word B or data write that closes the buffer. A wrong sequencing state shows up on the next strobe, as a pulse after a well-formed word or silence after a malformed one. Because every error is reported in the cycle after its cause, each scenario is checked at that cycle, and also one cycle later to confirm that the pulse dropped while the flag stayed set.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WANT_B = 2'd1,
        SEQ_DATA   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/txc_seq.sv
module txc_seq
    import txc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BUF_W     = 11,
    parameter int LEN_W     = 11,
    parameter int BYTES_W   = 3,
    parameter int FIRST_POS = 13,
    parameter int LAST_POS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_stb,
    input  logic              b_stb,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              data_wr,
    input  logic [BYTES_W-1:0] data_bytes,
    output logic              err_seq,
    output logic              err_bmis,
    output logic              err_len
);
    localparam int CNT_W  = LEN_W + 1;
    localparam int BCNT_W = BUF_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic              first;
        logic              last;
        logic [BUF_W-1:0]  size;
        logic [WORD_W-1:0] b_ref;
        logic              open;
        logic [BCNT_W-1:0] buf_cnt;
        logic [CNT_W-1:0]  pkt_cnt;
    } seq_s;

    seq_s r_q, r_d;

    logic              take_a, do_close, new_first;
    logic [WORD_W-1:0] bref_eff;
    logic [CNT_W-1:0]  pkt_total, pkt_sum;
    logic [CNT_W:0]    pkt_wide;
    logic [BCNT_W-1:0] buf_sum;

    always_comb begin
        r_d       = r_q;
        take_a    = 1'b0;
        do_close  = 1'b0;
        err_seq   = 1'b0;
        err_bmis  = 1'b0;
        err_len   = 1'b0;
        bref_eff  = r_q.b_ref;
        pkt_total = r_q.pkt_cnt;
        buf_sum   = r_q.buf_cnt + BCNT_W'(data_bytes);
        pkt_wide  = {1'b0, r_q.pkt_cnt} + (CNT_W + 1)'(data_bytes);
        pkt_sum   = pkt_wide[CNT_W] ? '1 : pkt_wide[CNT_W-1:0];

        unique case (r_q.st)
            SEQ_IDLE: begin
                if (a_stb)      take_a  = 1'b1;
                else if (b_stb) err_seq = 1'b1;
            end
            SEQ_WANT_B: begin
                if (a_stb) begin
                    err_seq = 1'b1;
                    take_a  = 1'b1;
                end else if (b_stb) begin
                    bref_eff = r_q.first ? cmd_word : r_q.b_ref;
                    if (!r_q.first && (cmd_word != r_q.b_ref)) err_bmis = 1'b1;
                    r_d.b_ref   = bref_eff;
                    r_d.buf_cnt = '0;
                    if (r_q.size == '0) do_close = 1'b1;
                    else                r_d.st   = SEQ_DATA;
                end
            end
            SEQ_DATA: begin
                if (a_stb) begin
                    err_seq = 1'b1;
                    take_a  = 1'b1;
                end else if (b_stb) begin
                    err_seq = 1'b1;
                end else if (data_wr) begin
                    r_d.buf_cnt = buf_sum;
                    r_d.pkt_cnt = pkt_sum;
                    pkt_total   = pkt_sum;
                    if (buf_sum >= {1'b0, r_q.size}) do_close = 1'b1;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase

        if (do_close) begin
            r_d.st   = SEQ_IDLE;
            r_d.open = !r_q.last;
            if (r_q.last && (pkt_total != {1'b0, bref_eff[LEN_W-1:0]}))
                err_len = 1'b1;
        end

        new_first = cmd_word[FIRST_POS] | !r_q.open;
        if (take_a) begin
            if (!cmd_word[FIRST_POS] && !r_q.open) err_seq = 1'b1;
            r_d.st    = SEQ_WANT_B;
            r_d.first = new_first;
            r_d.last  = cmd_word[LAST_POS];
            r_d.size  = cmd_word[BUF_W-1:0];
            if (new_first) begin
                r_d.pkt_cnt = '0;
                r_d.open    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/txc_ovf.sv
module txc_ovf (
    input  logic data_wr,
    input  logic dfifo_full,
    input  logic sfifo_wr,
    input  logic sfifo_full,
    input  logic sts_ovr_allow,
    output logic err_dovf,
    output logic err_sovf
);
    always_comb begin
        err_dovf = data_wr & dfifo_full;
        err_sovf = sfifo_wr & sfifo_full & ~sts_ovr_allow;
    end
endmodule

// File: rtl/txc_errreg.sv
module txc_errreg #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] err_src,
    input  logic             err_clr,
    output logic             err_flag,
    output logic             err_pulse
);
    typedef struct packed {
        logic flag;
        logic pulse;
    } err_s;

    err_s e_q, e_d;
    logic any_err;

    always_comb begin
        any_err  = |err_src;
        e_d.flag  = (e_q.flag & ~err_clr) | any_err;
        e_d.pulse = any_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign err_flag  = e_q.flag;
    assign err_pulse = e_q.pulse;
endmodule

// File: rtl/tx_cmd_checker.sv
module tx_cmd_checker #(
    parameter int WORD_W    = 32,
    parameter int BUF_W     = 11,
    parameter int LEN_W     = 11,
    parameter int BYTES_W   = 3,
    parameter int FIRST_POS = 13,
    parameter int LAST_POS  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_a_stb,
    input  logic               cmd_b_stb,
    input  logic [WORD_W-1:0]  cmd_word,
    input  logic               data_wr,
    input  logic [BYTES_W-1:0] data_bytes,
    input  logic               dfifo_full,
    input  logic               sfifo_wr,
    input  logic               sfifo_full,
    input  logic               sts_ovr_allow,
    input  logic               err_clr,
    output logic               err_flag,
    output logic               err_pulse
);
    localparam int N_SRC = 5;

    logic err_seq, err_bmis, err_len, err_dovf, err_sovf;

    txc_seq #(
        .WORD_W(WORD_W), .BUF_W(BUF_W), .LEN_W(LEN_W),
        .BYTES_W(BYTES_W), .FIRST_POS(FIRST_POS), .LAST_POS(LAST_POS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .a_stb(cmd_a_stb), .b_stb(cmd_b_stb), .cmd_word(cmd_word),
        .data_wr(data_wr), .data_bytes(data_bytes),
        .err_seq(err_seq), .err_bmis(err_bmis), .err_len(err_len)
    );

    txc_ovf u_ovf (
        .data_wr(data_wr), .dfifo_full(dfifo_full),
        .sfifo_wr(sfifo_wr), .sfifo_full(sfifo_full),
        .sts_ovr_allow(sts_ovr_allow),
        .err_dovf(err_dovf), .err_sovf(err_sovf)
    );

    txc_errreg #(.N_SRC(N_SRC)) u_err (
        .clk(clk), .rst_n(rst_n),
        .err_src({err_seq, err_bmis, err_len, err_dovf, err_sovf}),
        .err_clr(err_clr),
        .err_flag(err_flag), .err_pulse(err_pulse)
    );
endmodule

// File: rtl/tx_cmd_checker_sva.sv
module tx_cmd_checker_sva #(
    parameter int WORD_W  = 32,
    parameter int BYTES_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_a_stb,
    input logic               cmd_b_stb,
    input logic [WORD_W-1:0]  cmd_word,
    input logic               data_wr,
    input logic [BYTES_W-1:0] data_bytes,
    input logic               dfifo_full,
    input logic               sfifo_wr,
    input logic               sfifo_full,
    input logic               sts_ovr_allow,
    input logic               err_clr,
    input logic               err_flag,
    input logic               err_pulse
);
    logic quiet;
    assign quiet = !cmd_a_stb && !cmd_b_stb && !data_wr && !sfifo_wr;

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && quiet) |=> !err_flag);

    assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_flag);

    assert_rise_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> err_pulse);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !err_pulse);

    assert_dfifo_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && dfifo_full) |=> (err_pulse && err_flag));

    assert_sfifo_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sfifo_wr && sfifo_full && !sts_ovr_allow) |=> err_pulse);

    logic unused_ok;
    assign unused_ok = ^{cmd_word, data_bytes};
endmodule

bind tx_cmd_checker tx_cmd_checker_sva #(.WORD_W(WORD_W), .BYTES_W(BYTES_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .cmd_a_stb(cmd_a_stb), .cmd_b_stb(cmd_b_stb),
    .cmd_word(cmd_word), .data_wr(data_wr), .data_bytes(data_bytes),
    .dfifo_full(dfifo_full), .sfifo_wr(sfifo_wr), .sfifo_full(sfifo_full),
    .sts_ovr_allow(sts_ovr_allow), .err_clr(err_clr),
    .err_flag(err_flag), .err_pulse(err_pulse)
);

// File: tb/tb_tx_cmd_checker.sv
`timescale 1ns/1ps
module tb_tx_cmd_checker;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_a_stb = 0, cmd_b_stb = 0;
    logic [31:0] cmd_word = '0;
    logic        data_wr = 0;
    logic [2:0]  data_bytes = '0;
    logic        dfifo_full = 0, sfifo_wr = 0, sfifo_full = 0;
    logic        sts_ovr_allow = 0, err_clr = 0;
    logic        err_flag, err_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    tx_cmd_checker dut (
        .clk(clk), .rst_n(rst_n), .cmd_a_stb(cmd_a_stb), .cmd_b_stb(cmd_b_stb),
        .cmd_word(cmd_word), .data_wr(data_wr), .data_bytes(data_bytes),
        .dfifo_full(dfifo_full), .sfifo_wr(sfifo_wr), .sfifo_full(sfifo_full),
        .sts_ovr_allow(sts_ovr_allow), .err_clr(err_clr),
        .err_flag(err_flag), .err_pulse(err_pulse)
    );

    typedef struct packed {
        logic        a;
        logic        b;
        logic [31:0] w;
        logic        d;
        logic [2:0]  n;
        logic        df;
        logic        s;
        logic        sf;
        logic        al;
        logic        cl;
        logic        ep;
        logic        ef;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // fields: a, b, word, data_wr, bytes, dfull, swr, sfull, allow, clr, exp_pulse, exp_flag, req
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,32'h0000_3008,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 single buffer
        '{1'b0,1'b1,32'hAB00_0008,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 equal: no error
        '{1'b1,1'b0,32'h0000_2004,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 two buffers
        '{1'b0,1'b1,32'h0000_0008,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
        '{1'b1,1'b0,32'h0000_1004,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
        '{1'b0,1'b1,32'h0001_0008,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2}, // R2 mismatch upper bit
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd9}, // R9 still counting
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6}, // R6 clear
        '{1'b1,1'b0,32'h0000_3004,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
        '{1'b0,1'b1,32'h0000_0006,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd3}, // R3 4 vs 6
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6},
        '{1'b0,1'b0,32'h0,        1'b1,3'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd4}, // R4 overflow
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6},
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd5}, // R5 allowed
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd5}, // R5 not allowed
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd7}, // R7 pulse drops
        '{1'b0,1'b0,32'h0,        1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6}
    };

    task automatic idle_inputs();
        cmd_a_stb = 0; cmd_b_stb = 0; cmd_word = '0; data_wr = 0; data_bytes = '0;
        dfifo_full = 0; sfifo_wr = 0; sfifo_full = 0; sts_ovr_allow = 0; err_clr = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic ep, input logic ef);
        checks++;
        if (err_pulse !== ep || err_flag !== ef) begin
            errors++;
            $display("FAIL %s: pulse/flag actual %b/%b expected %b/%b at %0t",
                     req, err_pulse, err_flag, ep, ef, $time);
        end
    endtask

    task automatic cmd(input logic is_a, input logic [31:0] w);
        idle_inputs();
        cmd_a_stb = is_a; cmd_b_stb = !is_a; cmd_word = w;
        tick();
    endtask

    task automatic wr(input logic [2:0] n);
        idle_inputs();
        data_wr = 1; data_bytes = n;
        tick();
    endtask

    task automatic clear();
        idle_inputs();
        err_clr = 1;
        tick();
        idle_inputs();
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 1'b0, 1'b0);
        tick();
        check("R1", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            cmd_a_stb = VECS[i].a; cmd_b_stb = VECS[i].b; cmd_word = VECS[i].w;
            data_wr = VECS[i].d; data_bytes = VECS[i].n; dfifo_full = VECS[i].df;
            sfifo_wr = VECS[i].s; sfifo_full = VECS[i].sf; sts_ovr_allow = VECS[i].al;
            err_clr = VECS[i].cl;
            tick();
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ep, VECS[i].ef);
        end
        idle_inputs();

        // R8: word A while word B awaited
        cmd(1, 32'h3004); check("R8", 0, 0);
        cmd(1, 32'h3004); check("R8", 1, 1);
        cmd(0, 32'h0004); check("R9", 0, 1);
        wr(3'd4);         check("R9", 0, 1);
        clear();          check("R6", 0, 0);

        // R8: word B with no pending A
        cmd(0, 32'h0004); check("R8", 1, 1);
        clear();

        // R8: non-first A with no packet open, then treated as a new packet
        cmd(1, 32'h1004); check("R8", 1, 1);
        cmd(0, 32'h0004); check("R8", 0, 1);
        wr(3'd4);         check("R8", 0, 1);
        clear();

        // R8/R9: premature A during data, then good packet
        cmd(1, 32'h3008); cmd(0, 32'h0008);
        wr(3'd4);         check("R8", 0, 0);
        cmd(1, 32'h3004); check("R8", 1, 1);
        cmd(0, 32'h0004); wr(3'd4); check("R9", 0, 1);
        clear();

        // R10: zero-size buffer closes on word B
        cmd(1, 32'h3000); cmd(0, 32'h0000); check("R10", 0, 0);
        cmd(1, 32'h3000); cmd(0, 32'h0001); check("R10", 1, 1);
        clear();

        // R11: data with no buffer pending is not counted
        wr(3'd4); check("R11", 0, 0);
        cmd(1, 32'h3004); cmd(0, 32'h0004); wr(3'd4); check("R11", 0, 0);

        // R3: overshoot closes buffer with mismatching total
        cmd(1, 32'h3005); cmd(0, 32'h0005);
        wr(3'd4); check("R3", 0, 0);
        wr(3'd4); check("R3", 1, 1);
        clear();

        // R6: set wins over clear in the same cycle
        idle_inputs(); data_wr = 1; data_bytes = 3'd1; dfifo_full = 1; err_clr = 1;
        tick(); check("R6", 1, 1);
        clear(); check("R6", 0, 0);

        // R7: coinciding errors give one pulse
        idle_inputs(); data_wr = 1; data_bytes = 3'd1; dfifo_full = 1; sfifo_wr = 1; sfifo_full = 1;
        tick(); check("R7", 1, 1);
        idle_inputs(); tick(); check("R7", 0, 1);
        clear(); check("R7", 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule